// File: doc/BRIEF.md
# AUX Native Request Engine

This block carries out one native read or native write on a display auxiliary channel at a time. A host gives it a 16-bit register address, a direction and a byte count. The block builds a four-byte request header, adds the payload for writes, and sends the message one byte at a time to a transport layer. The transport layer handles line coding, preamble and sync. The block then reads the reply stream that the transport layer returns. It checks the transport's status code and the native-reply field of the reply command byte, and decides whether to finish, retry at once, or wait and retry. Read data from an accepted reply goes to the host, cut to the number of bytes that was asked for.

Four interfaces carry data, and each uses valid/ready. A transfer happens on a clock edge where both valid and ready are high. A source that raises valid holds it and its data until the transfer. The command port (`cmd_*`) is ready only while the engine is idle. Write payload (`wr_*`) is taken after the command and held internally, so a retry can send it again. Message bytes leave on `tx_*`. Replies arrive on `rsp_*`. While read data is being passed to `rd_*`, `rsp_ready` follows `rd_ready`, so the host can slow the transport down. Every other reply beat is taken at once.

Status codes on `status`: 0 ok, 1 timeout, 2 error, 3 retries exhausted.

Top module: `aux_native_req`

## Requirements
- R1: The first three message bytes are the address low byte, then the address high byte, then the command byte. The command byte is 0x80 for a write and 0x90 for a read.
- R2: The fourth header byte holds two values. Bits 7:4 hold the total message length modulo 16: 4 plus the count for a write, 4 for a read. Bits 3:0 hold the count minus one. A 16-byte write therefore gives 0x4F.
- R3: A write sends its payload bytes in order right after the header, and `tx_last` marks the final byte. A count of 0 or above 16 is rejected. The rejection gives done with status 2 in the cycle after the command is accepted, and `tx_valid` never rises.
- R4: A read request is the header only. Each reply is a beat stream: beat 0 carries the transport status in `rsp_status` and the reply command in `rsp_data`, and later beats carry data. On an accepted read, data bytes are passed to `rd_*` up to the requested count. `rd_last` is set on the requested count or on the final reply beat, whichever comes first. Extra bytes are dropped. Data from a reply that is not accepted is never passed on.
- R5: Transport status 2 (busy) starts a new attempt, with `tx_valid` high in the cycle after the final reply beat. Status 1 ends with status 1 (timeout). Status 3 ends with status 2 (error).
- R6: When the transport status is 0, bits 5:4 of the reply command decide the result. 0 (ACK) ends with status 0. 2 (DEFER) waits DEFER_CYCLES cycles, so `tx_valid` rises DEFER_CYCLES+1 cycles after the final reply beat. Any other value ends with status 2.
- R7: At most MAX_TRIES (4) attempts are made. A retry that would go past this limit ends with status 3 instead.
- R8: `done` is a single-cycle pulse that comes one cycle after the final reply beat. `status` is valid while `done` is high. `busy` is high from the cycle after the command is accepted through the done cycle. `cmd_ready` is high only when `busy` is low.
- R9: While `tx_ready` is low, the engine holds `tx_valid`, `tx_data` and `tx_last` steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_addr | input | 16 | Register address |
| cmd_len | input | 5 | Byte count (1 to 16) |
| wr_valid | input | 1 | Payload byte offered |
| wr_ready | output | 1 | Payload byte taken |
| wr_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Message byte offered |
| tx_ready | input | 1 | Transport takes byte |
| tx_data | output | 8 | Message byte |
| tx_last | output | 1 | Final byte of message |
| rsp_valid | input | 1 | Reply beat offered |
| rsp_ready | output | 1 | Reply beat taken |
| rsp_status | input | 2 | Transport status (beat 0) |
| rsp_data | input | 8 | Reply command (beat 0) or data |
| rsp_last | input | 1 | Final reply beat |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| status | output | 2 | Completion status |

## Verification
Each message byte is compared in the cycle it is transferred. Read bytes are compared in the same cycle as the reply beat that carries them, because `rd_*` is a combinational pass-through. The cycle count from the final reply beat to the next `tx_valid` is measured, with a required value of 1 after busy and DEFER_CYCLES+1 after DEFER. The completion pulse is expected exactly one cycle after the final reply beat, or one cycle after a rejected command is accepted. A monitor at every falling edge flags `done` in any other cycle. Back-pressure on `tx_ready` and `rd_ready` follows a fixed stall pattern, so held bytes are seen over more than one cycle.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_TIMEOUT   = 2'd1,
    ST_ERROR     = 2'd2,
    ST_EXHAUSTED = 2'd3
  } aux_status_e;

  localparam logic [1:0] TP_OK      = 2'd0;
  localparam logic [1:0] TP_TIMEOUT = 2'd1;
  localparam logic [1:0] TP_BUSY    = 2'd2;
  localparam logic [1:0] TP_CHERR   = 2'd3;

  localparam logic [1:0] RP_ACK   = 2'd0;
  localparam logic [1:0] RP_DEFER = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SEND, S_REPLY, S_WAIT, S_DONE
  } eng_state_e;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build #(
  parameter int LEN_W = 5,
  parameter logic [3:0] CMD_WR = 4'h8,
  parameter logic [3:0] CMD_RD = 4'h9
) (
  input  logic [15:0]      addr,
  input  logic             is_write,
  input  logic [LEN_W-1:0] len,
  output logic [3:0][7:0]  hdr
);
  logic [7:0] total;
  logic [7:0] cnt_m1;

  always_comb begin
    total  = is_write ? (8'd4 + 8'(len)) : 8'd4;
    cnt_m1 = 8'(len) - 8'd1;
    hdr[0] = addr[7:0];
    hdr[1] = addr[15:8];
    hdr[2] = {(is_write ? CMD_WR : CMD_RD), 4'h0};
    hdr[3] = {total[3:0], cnt_m1[3:0]};
  end
endmodule

// File: rtl/aux_pay_buf.sv
module aux_pay_buf #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);
  logic [DEPTH-1:0][7:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) mem[g] <= wr_byte;
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int CYCLES = 20000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  logic          running;
  logic [CW-1:0] cnt;

  assign expired = running && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (expired) running <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  wait_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !start);
endmodule

// File: rtl/aux_native_req.sv
module aux_native_req
  import aux_req_pkg::*;
#(
  parameter int MAX_PAYLOAD  = 16,
  parameter int MAX_TRIES    = 4,
  parameter int DEFER_CYCLES = 20000,
  parameter logic [3:0] CMD_WR = 4'h8,
  parameter logic [3:0] CMD_RD = 4'h9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  output logic                             cmd_ready,
  input  logic                             cmd_write,
  input  logic [15:0]                      cmd_addr,
  input  logic [$clog2(MAX_PAYLOAD+1)-1:0] cmd_len,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [7:0]                       wr_data,
  output logic                             tx_valid,
  input  logic                             tx_ready,
  output logic [7:0]                       tx_data,
  output logic                             tx_last,
  input  logic                             rsp_valid,
  output logic                             rsp_ready,
  input  logic [1:0]                       rsp_status,
  input  logic [7:0]                       rsp_data,
  input  logic                             rsp_last,
  output logic                             rd_valid,
  input  logic                             rd_ready,
  output logic [7:0]                       rd_data,
  output logic                             rd_last,
  output logic                             busy,
  output logic                             done,
  output logic [1:0]                       status
);
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1);
  localparam int CNT_W = $clog2(MAX_PAYLOAD + 5);
  localparam int IDX_W = $clog2(MAX_PAYLOAD);
  localparam int TRY_W = $clog2(MAX_TRIES) + 1;

  eng_state_e       state;
  logic             is_wr;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic             first;
  logic [1:0]       tp_q, rp_q;
  logic [LEN_W-1:0] rd_cnt;
  aux_status_e      stat_q;

  logic [3:0][7:0]  hdr;
  logic [7:0]       pay_byte;
  logic [CNT_W-1:0] msg_len;
  logic             tmr_start, tmr_exp;
  logic [1:0]       tp_now, rp_now;
  logic             fwd, rsp_fire, end_beat, last_try, bad_len;
  logic             go_send, go_wait, go_done;
  aux_status_e      fin_stat;

  aux_hdr_build #(.LEN_W(LEN_W), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)) u_hdr (
    .addr(addr_q), .is_write(is_wr), .len(len_q), .hdr(hdr)
  );

  aux_pay_buf #(.DEPTH(MAX_PAYLOAD)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(state == S_LOAD && wr_valid),
    .wr_idx(IDX_W'(cnt)), .wr_byte(wr_data),
    .rd_idx(IDX_W'(cnt - CNT_W'(4))), .rd_byte(pay_byte)
  );

  aux_wait_timer #(.CYCLES(DEFER_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .expired(tmr_exp)
  );

  always_comb begin
    msg_len   = is_wr ? (CNT_W'(len_q) + CNT_W'(4)) : CNT_W'(4);
    cmd_ready = (state == S_IDLE);
    wr_ready  = (state == S_LOAD);
    tx_valid  = (state == S_SEND);
    tx_data   = (cnt < CNT_W'(4)) ? hdr[cnt[1:0]] : pay_byte;
    tx_last   = (cnt == msg_len - CNT_W'(1));
    busy      = (state != S_IDLE);
    done      = (state == S_DONE);
    status    = stat_q;
    bad_len   = (cmd_len == '0) || (cmd_len > LEN_W'(MAX_PAYLOAD));

    tp_now   = first ? rsp_status : tp_q;
    rp_now   = first ? rsp_data[5:4] : rp_q;
    fwd      = !first && !is_wr && tp_q == TP_OK && rp_q == RP_ACK && rd_cnt < len_q;
    rd_valid = (state == S_REPLY) && rsp_valid && fwd;
    rd_data  = rsp_data;
    rd_last  = rsp_last || (rd_cnt == len_q - LEN_W'(1));
    rsp_ready = (state == S_REPLY) && (fwd ? rd_ready : 1'b1);
    rsp_fire  = rsp_valid && rsp_ready;
    end_beat  = (state == S_REPLY) && rsp_fire && rsp_last;
    last_try  = (tries == TRY_W'(MAX_TRIES - 1));

    go_send = 1'b0; go_wait = 1'b0; go_done = 1'b0; fin_stat = ST_ERROR;
    unique case (tp_now)
      TP_TIMEOUT: begin go_done = 1'b1; fin_stat = ST_TIMEOUT; end
      TP_CHERR:   go_done = 1'b1;
      TP_BUSY:    go_send = 1'b1;
      default: begin
        if (rp_now == RP_ACK) begin go_done = 1'b1; fin_stat = ST_OK; end
        else if (rp_now == RP_DEFER) go_wait = 1'b1;
        else go_done = 1'b1;
      end
    endcase
    if ((go_send || go_wait) && last_try) begin
      go_send = 1'b0; go_wait = 1'b0; go_done = 1'b1; fin_stat = ST_EXHAUSTED;
    end
    tmr_start = end_beat && go_wait;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; is_wr <= 1'b0; addr_q <= '0; len_q <= '0;
      cnt <= '0; tries <= '0; first <= 1'b0; tp_q <= '0; rp_q <= '0;
      rd_cnt <= '0; stat_q <= ST_OK;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          is_wr <= cmd_write; addr_q <= cmd_addr; len_q <= cmd_len;
          cnt <= '0; tries <= '0;
          if (bad_len) begin stat_q <= ST_ERROR; state <= S_DONE; end
          else state <= cmd_write ? S_LOAD : S_SEND;
        end
        S_LOAD: if (wr_valid) begin
          if (cnt == CNT_W'(len_q) - CNT_W'(1)) begin cnt <= '0; state <= S_SEND; end
          else cnt <= cnt + 1'b1;
        end
        S_SEND: if (tx_ready) begin
          if (tx_last) begin
            state <= S_REPLY; first <= 1'b1; rd_cnt <= '0; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_REPLY: if (rsp_fire) begin
          if (first) begin tp_q <= rsp_status; rp_q <= rsp_data[5:4]; first <= 1'b0; end
          if (fwd) rd_cnt <= rd_cnt + 1'b1;
          if (rsp_last) begin
            if (go_done) begin stat_q <= fin_stat; state <= S_DONE; end
            else begin
              tries <= tries + 1'b1;
              state <= go_wait ? S_WAIT : S_SEND;
            end
          end
        end
        S_WAIT: if (tmr_exp) state <= S_SEND;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done |-> busy) and (cmd_ready |-> !busy));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R7
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries < TRY_W'(MAX_TRIES)));
  // R4
  rd_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> !rd_valid);
  // R3
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && bad_len) |=> (done && status == 2'd2 && !tx_valid));
  // R5
  busy_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && first && rsp_status == TP_BUSY && !last_try) |=> tx_valid);
endmodule

// File: tb/tb_aux_native_req.sv
module tb_aux_native_req;
  localparam int DEFER = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0; logic [15:0] cmd_addr = 0; logic [4:0] cmd_len = 0;
  logic wr_valid = 0; logic [7:0] wr_data = 0;
  logic tx_ready = 0;
  logic rsp_valid = 0; logic [1:0] rsp_status = 0; logic [7:0] rsp_data = 0; logic rsp_last = 0;
  logic rd_ready = 0;
  logic cmd_ready, wr_ready, tx_valid, tx_last, rsp_ready, rd_valid, rd_last, busy, done;
  logic [7:0] tx_data, rd_data; logic [1:0] status;

  int n_chk = 0, n_fail = 0, cyc = 0, stall = 0;
  bit done_ok = 0, finished = 0;
  logic [7:0] pl [16];
  logic [1:0] s_tp [8]; logic [7:0] s_cmd [8]; int s_nd [8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aux_native_req #(.DEFER_CYCLES(DEFER)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .busy(busy), .done(done), .status(status));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done_ok && !finished)
    chk(done == 1'b0, "R8 stray done", done, 0);

  function automatic bit stall_now();
    stall++;
    return (stall % 3) == 0;
  endfunction

  task automatic run(bit w, logic [15:0] a, int len, int exp_stat);
    int t_hs = 0, exp_gap = 0, msg, res;
    logic [7:0] exp_b [20];
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_len = 5'(len);
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (len == 0 || len > 16) begin
      done_ok = 1;
      chk(done == 1 && status == 2'd2, "R3 reject status", {done, status}, 6);
      chk(tx_valid == 0, "R3 reject no tx", tx_valid, 0);
      @(negedge clk); done_ok = 0;
      chk(busy == 0, "R8 idle after reject", busy, 0);
      return;
    end
    if (w) for (int i = 0; i < len; ) begin
      wr_valid = 1; wr_data = pl[i]; #1;
      if (wr_ready) i++;
      @(posedge clk); #1 wr_valid = 0; @(negedge clk);
    end
    exp_b[0] = a[7:0]; exp_b[1] = a[15:8]; exp_b[2] = w ? 8'h80 : 8'h90;
    exp_b[3] = {4'((w ? 4 + len : 4) % 16), 4'(len - 1)};
    for (int i = 0; i < len; i++) exp_b[4 + i] = pl[i];
    msg = w ? 4 + len : 4;
    for (int at = 0; at < 8; at++) begin
      int i = 0;
      bit seen = 0;
      while (i < msg) begin
        tx_ready = !stall_now(); #1;
        if (tx_valid && !seen) begin
          seen = 1;
          if (at > 0) chk(cyc - t_hs == exp_gap, at > 0 && exp_gap == 1 ? "R5 busy retry gap" : "R6 defer gap", cyc - t_hs, exp_gap);
        end
        if (tx_valid && tx_ready) begin
          chk(tx_data == exp_b[i], i < 3 ? "R1 header byte" : (i == 3 ? "R2 length byte" : "R3 payload byte"), tx_data, exp_b[i]);
          chk(tx_last == (i == msg - 1), "R3 tx_last", tx_last, i == msg - 1);
          i++;
        end
        @(posedge clk); #1 tx_ready = 0; @(negedge clk);
      end
      for (int k = 0; k <= s_nd[at]; ) begin
        bit f = !w && s_tp[at] == 0 && s_cmd[at][5:4] == 0 && k >= 1 && k <= len;
        rsp_valid = 1; rsp_status = (k == 0) ? s_tp[at] : 2'd0;
        rsp_data = (k == 0) ? s_cmd[at] : 8'(8'hA0 + k + at * 16);
        rsp_last = (k == s_nd[at]); rd_ready = !stall_now(); #1;
        chk(rd_valid == f, "R4 read forward", rd_valid, f);
        if (rsp_ready) begin
          if (f) begin
            chk(rd_data == rsp_data, "R4 read data", rd_data, rsp_data);
            chk(rd_last == (k == len || k == s_nd[at]), "R4 rd_last", rd_last, k == len || k == s_nd[at]);
          end
          if (k == s_nd[at]) t_hs = cyc;
          k++;
        end
        @(posedge clk); #1 rsp_valid = 0; rsp_last = 0;
        if (k <= s_nd[at]) @(negedge clk);
      end
      res = -1;
      if (s_tp[at] == 1) res = 1;
      else if (s_tp[at] == 3) res = 2;
      else if (s_tp[at] == 2) exp_gap = 1;
      else if (s_cmd[at][5:4] == 0) res = 0;
      else if (s_cmd[at][5:4] == 2) exp_gap = DEFER + 1;
      else res = 2;
      if (res < 0 && at == 3) res = 3;
      if (res >= 0) begin
        done_ok = 1; @(negedge clk);
        chk(done == 1 && status == 2'(res), res == 3 ? "R7 exhausted status" : "R8 done status", {done, status}, 4 | res);
        @(negedge clk); done_ok = 0;
        chk(done == 0 && busy == 0 && cmd_ready == 1, "R8 single pulse idle", {done, busy, cmd_ready}, 1);
        chk(res == exp_stat, "R6 model status", res, exp_stat);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic script1(logic [1:0] tp, logic [7:0] c, int nd);
    s_tp[0] = tp; s_cmd[0] = c; s_nd[0] = nd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cmd_ready == 1 && done == 0 && tx_valid == 0 && rd_valid == 0,
        "R8 reset state", {busy, cmd_ready, done, tx_valid, rd_valid}, 8);
    for (int i = 0; i < 16; i++) pl[i] = 8'(8'h30 + i * 7);
    script1(0, 8'h00, 0); run(1, 16'h0100, 1, 0);
    script1(0, 8'h00, 8); run(0, 16'h0000, 8, 0);
    script1(0, 8'h00, 5); run(0, 16'h0202, 2, 0);
    script1(0, 8'h00, 2); run(0, 16'h0303, 4, 0);
    script1(0, 8'h00, 0); run(1, 16'hBEEF, 16, 0);
    run(1, 16'h0001, 17, 2);
    run(0, 16'h0001, 0, 2);
    s_tp[0] = 2; s_cmd[0] = 0; s_nd[0] = 0; s_tp[1] = 0; s_cmd[1] = 0; s_nd[1] = 3;
    run(0, 16'h1234, 3, 0);
    s_tp[0] = 0; s_cmd[0] = 8'h20; s_nd[0] = 2; s_tp[1] = 0; s_cmd[1] = 0; s_nd[1] = 2;
    run(0, 16'h2345, 2, 0);
    script1(1, 8'h00, 0); run(1, 16'h0010, 2, 1);
    script1(3, 8'h00, 0); run(0, 16'h0011, 1, 2);
    script1(0, 8'h10, 0); run(1, 16'h0012, 1, 2);
    script1(0, 8'h30, 0); run(0, 16'h0013, 1, 2);
    for (int i = 0; i < 4; i++) begin s_tp[i] = 0; s_cmd[i] = 8'h20; s_nd[i] = 0; end
    run(1, 16'h0600, 3, 3);
    s_tp[0] = 2; s_tp[1] = 0; s_tp[2] = 2; s_tp[3] = 2;
    run(0, 16'h0700, 1, 3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule